// File: doc/BRIEF.md
# Counted Pulse Train Generator

This block drives one output pin with a programmed number of pulses. Software loads a configuration word X, whose low half sets a base period in clock cycles and whose high half sets a duty threshold. It then writes a pulse count Y. A free-running down-counter steps through the base period and reloads itself at the end of each period. While the count is non-zero, the pin is high in every cycle where the counter is above the threshold. The count falls by one at each period boundary, and a completion flag rises once the last period has ended.

The enable input `dir` is active high for running and acts as a reset while low. A low `dir` forces the pin low, clears the count and any queued count, and clears the completion flag. The base counter starts running on the cycle in which `dir` goes high. It is never realigned by a count write, so a new group always begins on a whole period boundary of that running counter. A count written while a group is running is queued, and it follows the current group without a gap.

Top module: `pulse_train_gen`

## Requirements
- R1: With `dir` high, the base counter takes the value P for one cycle and then counts down one step per clock to 1, then reloads P, so every period lasts exactly P cycles. P is X[PW-1:0], and a value of 0 is treated as 1.
- R2: During an active group, in the k-th cycle of a period (k = 0 .. P-1), the pin is high exactly when P-k is greater than the threshold T = X[2PW-1:PW]. With T = 0 the pin is high through the whole group.
- R3: A non-zero Y write that the clock captures at the end of cycle w, counted from the first cycle with `dir` high as cycle 0, starts its group at the first period boundary cycle that is a multiple of P and at least w+2. A write right after `dir` rises therefore waits one full period.
- R4: A group of count N lasts exactly N periods. After it, the pin stays low.
- R5: `done_flag` goes high in the first cycle after the last period of a group. It stays high until `ack` is pulsed, and it is low in the cycle after the `ack`.
- R6: A non-zero Y write clears `done_flag` from the next cycle on. A Y write of zero is ignored: it starts nothing and leaves `done_flag` unchanged.
- R7: While `dir` is low, the pin is low in the same cycle. From the next clock edge on, `done_flag` is low and both the running count and the queued count are cleared. Y writes made while `dir` is low are ignored.
- R8: A non-zero Y write during a running group is queued. It starts at the boundary that ends the current group, with no idle period, and `done_flag` is not raised between the two groups.
- R9: The base counter keeps its phase across groups, so a group requested after an idle stretch still starts on a multiple of P counted from the rise of `dir`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir | input | 1 | Run enable; low holds the generator in reset |
| x_wr | input | 1 | Strobe that loads `x_data` into the configuration word |
| x_data | input | 2*PERIOD_W | Low half: base period; high half: duty threshold |
| y_wr | input | 1 | Strobe that writes a pulse count |
| y_data | input | COUNT_W | Pulse count (zero is ignored) |
| ack | input | 1 | Clears the completion flag |
| pin_out | output | 1 | Pulse output |
| done_flag | output | 1 | Group-complete flag |

## Verification
The bench builds the block with a 4-bit period field and a 4-bit count. With those widths it can sweep every period from 0 to 6, every threshold from 0 to 6, counts of 1 to 3 and three write times, and compare each cycle against closed-form expected values. The small widths also make the zero-period clamp and the threshold-above-period case reachable within the sweep. Directed sequences on a period of 3 then cover queued groups, idle phase retention, zero writes, the acknowledge, and a `dir` drop in the middle of a group with a count queued.

// File: rtl/pulse_train_pkg.sv
// Shared defaults for the counted pulse train generator.
// Assumes nothing beyond being compiled before the modules that use it.
package pulse_train_pkg;
    localparam int unsigned PTG_PERIOD_W_DEF = 16;
    localparam int unsigned PTG_COUNT_W_DEF  = 32;
endpackage

// File: rtl/ptg_phase_ctr.sv
// Base-period down-counter. It counts from the effective period down to 1
// and then reloads. It is held at the reload value while not running.
// Assumes: period of 0 means one cycle; run is the enable from the top.
module ptg_phase_ctr #(
    parameter int unsigned PW = pulse_train_pkg::PTG_PERIOD_W_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] period,
    output logic [PW-1:0] phase,
    output logic          period_end
);
    logic [PW-1:0] period_eff;

    // Clamp a zero period to one cycle so the counter never stalls.
    always_comb period_eff = (period == '0) ? PW'(1) : period;

    // Last cycle of a period while running.
    always_comb period_end = run && (phase <= PW'(1));

    // Count down, reload at the boundary, and hold the reload value in reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase <= period_eff;
        end else if (phase <= PW'(1)) begin
            phase <= period_eff;
        end else begin
            phase <= phase - PW'(1);
        end
    end
endmodule

// File: rtl/ptg_count_ctl.sv
// Pulse-count control. It keeps the running count and one queued count,
// loads the queue at period boundaries and raises the completion flag.
// Assumes: period_end marks the last cycle of each base period.
module ptg_count_ctl #(
    parameter int unsigned CW = pulse_train_pkg::PTG_COUNT_W_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          period_end,
    input  logic          load_stb,
    input  logic [CW-1:0] load_val,
    input  logic          ack,
    output logic [CW-1:0] remain,
    output logic          done
);
    logic [CW-1:0] queued;
    logic          load_ok;
    logic          last_period;
    logic          finish;

    // Accept only non-zero writes while running.
    always_comb load_ok = run && load_stb && (load_val != '0);
    // Running count is on its final period (or idle) at this boundary.
    always_comb last_period = period_end && (remain <= CW'(1));
    // Group ends with nothing queued behind it.
    always_comb finish = period_end && (remain == CW'(1)) && (queued == '0);

    // Queued count: captured on a write, consumed when the running count empties.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            queued <= '0;
        end else if (load_ok) begin
            queued <= load_val;
        end else if (last_period) begin
            queued <= '0;
        end
    end

    // Running count: steps down once per period, refills from the queue.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            remain <= '0;
        end else if (period_end) begin
            if (remain > CW'(1)) begin
                remain <= remain - CW'(1);
            end else begin
                remain <= queued;
            end
        end
    end

    // Completion flag: a new write clears it, the end of a group sets it, ack clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            done <= 1'b0;
        end else if (load_ok) begin
            done <= 1'b0;
        end else if (finish) begin
            done <= 1'b1;
        end else if (ack) begin
            done <= 1'b0;
        end
    end
endmodule

// File: rtl/pulse_train_gen.sv
// Counted pulse train generator top. It holds the configuration word,
// joins the base counter and the count control, and forms the pin.
// Assumes: dir is synchronous to clk; x_wr and y_wr are one-cycle strobes.
module pulse_train_gen #(
    parameter int unsigned PERIOD_W = pulse_train_pkg::PTG_PERIOD_W_DEF,
    parameter int unsigned COUNT_W  = pulse_train_pkg::PTG_COUNT_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  dir,
    input  logic                  x_wr,
    input  logic [2*PERIOD_W-1:0] x_data,
    input  logic                  y_wr,
    input  logic [COUNT_W-1:0]    y_data,
    input  logic                  ack,
    output logic                  pin_out,
    output logic                  done_flag
);
    localparam int unsigned XW = 2 * PERIOD_W;

    logic [XW-1:0]       x_q;
    logic [PERIOD_W-1:0] period;
    logic [PERIOD_W-1:0] thresh;
    logic [PERIOD_W-1:0] phase;
    logic                period_end;
    logic [COUNT_W-1:0]  remain;
    logic                done_q;

    // Configuration word, writable whether or not the generator runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0;
        end else if (x_wr) begin
            x_q <= x_data;
        end
    end

    // Split the configuration word into its period and threshold halves.
    always_comb begin
        period = x_q[PERIOD_W-1:0];
        thresh = x_q[XW-1:PERIOD_W];
    end

    ptg_phase_ctr #(.PW(PERIOD_W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (dir),
        .period     (period),
        .phase      (phase),
        .period_end (period_end)
    );

    ptg_count_ctl #(.CW(COUNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (dir),
        .period_end (period_end),
        .load_stb   (y_wr),
        .load_val   (y_data),
        .ack        (ack),
        .remain     (remain),
        .done       (done_q)
    );

    // Pin is high above the threshold while a count is live; dir low forces it low at once.
    always_comb pin_out = dir && (remain != '0) && (phase > thresh);

    // Completion flag straight from the count control.
    always_comb done_flag = done_q;
endmodule

// File: rtl/pulse_train_gen_chk.sv
// Assertion checker for the pulse train generator, attached by bind.
// Assumes: it is connected to the internal phase, count and flag of the top.
module pulse_train_gen_chk #(
    parameter int unsigned PW = 16,
    parameter int unsigned CW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dir,
    input logic          y_wr,
    input logic [CW-1:0] y_data,
    input logic          ack,
    input logic [PW-1:0] phase,
    input logic [CW-1:0] remain,
    input logic          done,
    input logic          pin
);
    // R1: while running the counter never sits at zero.
    a_r1_phase_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        dir |-> (phase != '0));

    // R1: above 1 the counter steps down by exactly one.
    a_r1_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (dir && phase > PW'(1)) |=> (phase == $past(phase) - PW'(1)));

    // R2: the pin is never high without a live count.
    a_r2_pin_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
        pin |-> (remain != '0));

    // R4: the count changes only at a period boundary.
    a_r4_count_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (dir && phase > PW'(1)) |=> $stable(remain));

    // R5: the flag rises only after a final period.
    a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(remain) == CW'(1)));

    // R5: an acknowledge with no live count clears the flag.
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (dir && ack && remain == '0) |=> !done);

    // R6: a non-zero count write clears the flag.
    a_r6_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (dir && y_wr && y_data != '0) |=> !done);

    // R7: dir low forces the pin low in the same cycle.
    a_r7_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
        !dir |-> !pin);

    // R7: dir low clears the flag and count by the next edge.
    a_r7_dir_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !dir |=> (!done && remain == '0));
endmodule

bind pulse_train_gen pulse_train_gen_chk #(.PW(PERIOD_W), .CW(COUNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .dir    (dir),
    .y_wr   (y_wr),
    .y_data (y_data),
    .ack    (ack),
    .phase  (phase),
    .remain (remain),
    .done   (done_q),
    .pin    (pin_out)
);

// File: tb/pulse_train_gen_bench.sv
`timescale 1ns/1ps
module pulse_train_gen_bench;
    localparam int PW = 4;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dir = 1'b0;
    logic          x_wr = 1'b0;
    logic [2*PW-1:0] x_data = '0;
    logic          y_wr = 1'b0;
    logic [CW-1:0] y_data = '0;
    logic          ack = 1'b0;
    logic          pin_out;
    logic          done_flag;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pulse_train_gen #(.PERIOD_W(PW), .COUNT_W(CW)) u_pulse_train_gen (
        .clk(clk), .rst_n(rst_n), .dir(dir), .x_wr(x_wr), .x_data(x_data),
        .y_wr(y_wr), .y_data(y_data), .ack(ack),
        .pin_out(pin_out), .done_flag(done_flag)
    );

    task automatic chk(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    // One clock cycle with the given strobes; samples outputs mid-cycle.
    task automatic cyc(input logic yw, input int yv, input logic ak,
                       output logic p, output logic d);
        y_wr = yw; y_data = yv[CW-1:0]; ack = ak;
        @(negedge clk);
        p = pin_out; d = done_flag;
        @(posedge clk); #1;
        y_wr = 1'b0; ack = 1'b0;
    endtask

    // First boundary that is a multiple of pe and at least w+2.
    function automatic int start_of(input int w, input int pe);
        return ((w + 2 + pe - 1) / pe) * pe;
    endfunction

    // Expected pin inside a window [s, s+n*pe).
    function automatic logic pin_exp(input int c, input int s, input int n,
                                     input int pe, input int t);
        if (c < s || c >= s + n * pe) return 1'b0;
        return (pe - ((c - s) % pe)) > t;
    endfunction

    // Load X with dir low and let the counter take the new period.
    task automatic setup(input int p, input int t);
        logic pp, dd;
        dir = 1'b0;
        x_wr = 1'b1; x_data = {PW'(t), PW'(p)};
        cyc(1'b0, 0, 1'b0, pp, dd);
        x_wr = 1'b0;
        cyc(1'b0, 0, 1'b0, pp, dd);
        chk("R7", pp, 1'b0, "pin while dir low");
        chk("R7", dd, 1'b0, "done while dir low");
        dir = 1'b1;
    endtask

    initial begin
        #(200000 * 20);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic p, d;
        int pe, s;
        @(posedge clk); #1;
        cyc(1'b0, 0, 1'b0, p, d);
        cyc(1'b0, 0, 1'b0, p, d);
        chk("R7", p, 1'b0, "reset pin");
        chk("R5", d, 1'b0, "reset done");
        rst_n = 1'b1;

        // Sweep: period, threshold, count, write time (R1 R2 R3 R4 R5).
        for (int per = 0; per <= 6; per++) begin
            for (int t = 0; t <= 6; t++) begin
                for (int n = 1; n <= 3; n++) begin
                    for (int w = 0; w <= 2; w++) begin
                        pe = (per == 0) ? 1 : per;
                        s = start_of(w, pe);
                        setup(per, t);
                        for (int c = 0; c <= s + n * pe + 1; c++) begin
                            cyc(c == w, n, 1'b0, p, d);
                            if (c < s) chk("R3", p, 1'b0, $sformatf("wait p%0d t%0d n%0d c%0d", per, t, n, c));
                            else if (c < s + n * pe) chk("R2", p, pin_exp(c, s, n, pe, t), $sformatf("R1 shape p%0d t%0d n%0d c%0d", per, t, n, c));
                            else chk("R4", p, 1'b0, $sformatf("after group p%0d n%0d c%0d", per, n, c));
                            chk("R5", d, (c >= s + n * pe), $sformatf("done p%0d n%0d c%0d", per, n, c));
                        end
                    end
                end
            end
        end

        // Directed, period 3 threshold 1: queue (R8), zero write and clear (R6), phase (R9), ack (R5).
        setup(3, 1);
        for (int c = 0; c <= 28; c++) begin
            logic ew, ed, ep;
            int yv;
            ew = (c == 0 || c == 4 || c == 16 || c == 17);
            yv = (c == 16) ? 0 : ((c == 17) ? 1 : 2);
            cyc(ew, yv, c == 26, p, d);
            ep = pin_exp(c, 3, 4, 3, 1) | pin_exp(c, 21, 1, 3, 1);
            ed = (c >= 15 && c <= 17) || (c >= 24 && c <= 26);
            if (c < 15) chk("R8", p, ep, $sformatf("queued group c%0d", c));
            else chk("R9", p, ep, $sformatf("phase kept c%0d", c));
            if (c == 17) chk("R6", d, ed, "zero write ignored");
            else if (c == 18) chk("R6", d, ed, "nonzero write clears");
            else if (c >= 27) chk("R5", d, ed, "ack clears");
            else chk("R8", d, ed, $sformatf("done c%0d", c));
        end
        // Dir drop mid-group with a queued count (R7).
        for (int c = 29; c <= 34; c++) begin
            cyc(c == 29 || c == 34, (c == 29) ? 3 : 2, 1'b0, p, d);
            chk("R7", p, pin_exp(c, 33, 3, 3, 1), $sformatf("pre-drop c%0d", c));
        end
        dir = 1'b0;
        cyc(1'b0, 0, 1'b0, p, d);
        chk("R7", p, 1'b0, "pin low same cycle");
        cyc(1'b1, 2, 1'b0, p, d);
        chk("R7", p, 1'b0, "pin low while held");
        chk("R7", d, 1'b0, "done low while held");
        dir = 1'b1;
        for (int c = 0; c < 12; c++) begin
            cyc(1'b0, 0, 1'b0, p, d);
            chk("R7", p, 1'b0, $sformatf("count cleared c%0d", c));
            chk("R7", d, 1'b0, $sformatf("done cleared c%0d", c));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule